// File: doc/BRIEF.md
# Cycle-Bit Descriptor Ring Consumer

This block walks a ring of 16-byte descriptors that a producer places in a local memory, and hands each usable descriptor to a downstream engine over a ready/valid stream. The consumer does not use head and tail pointers. It keeps one internal cycle state bit and compares it with the cycle bit carried by each fetched descriptor. A match means the producer has filled that slot. A mismatch means the ring is drained, so the consumer parks until the producer rings the doorbell again.

Rings are built from segments (64 descriptors, 1024 bytes each) joined by link descriptors. A link descriptor is never passed downstream. It redirects the fetch pointer to the segment it names, and it can invert the expected cycle state so that the producer's wrap is followed. Software points the consumer at a ring with a base load, which also sets the cycle state to 1. The memory is read through a synchronous port with one cycle of latency.

Top module: `ring_desc_consumer`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` and `mem_rd_en` are 0.
- R2: `base_load` sets the fetch pointer to `base_blk` (a block index, byte address / 16) and the cycle state to 1. A later `doorbell` in idle reads that block first.
- R3: A descriptor is 128 bits: word0 is bits 31:0 and the control word (word3) is bits 127:96. The cycle bit is control bit 0, which is descriptor bit 96. A descriptor whose cycle bit equals the cycle state and that is not a link is presented unchanged on `out_desc`.
- R4: `out_type` carries control bits 15:10. `out_chain`, `out_ioc` and `out_imm` carry control bits 4, 5 and 6. Type codes are 1 normal, 2 setup, 3 data, 4 status, 5 isochronous, 6 link, 7 event data and 8 no-op.
- R5: A descriptor whose cycle bit differs from the cycle state gives no output and does not advance the pointer. The consumer stays idle until the next `doorbell`, which rereads the same block.
- R6: A descriptor of type 6 is never output. Its words 0 and 1 hold a 64-bit byte pointer. Bits ADDR_W-1:4 of that pointer become the next block index; the low 4 bits and the bits above ADDR_W are ignored. Fetching continues without a doorbell.
- R7: Bit 1 of a link's control word inverts the cycle state. When that bit is 0, the cycle state is unchanged.
- R8: While `out_valid` is high and `out_ready` is low, the output stays stable. When a descriptor is accepted, the pointer advances by one block.
- R9: A `doorbell` that arrives while the consumer is busy is remembered. The next ownership mismatch then triggers one immediate reread instead of going idle.
- R10: `base_load` aborts any fetch in progress. In the following cycle `out_valid` and `mem_rd_en` are low, and any remembered doorbell is dropped.
- R11: For an owned, non-link descriptor, `out_valid` rises exactly three clock edges after the edge that samples a `doorbell` in idle. Each fetch holds `mem_rd_en` high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_load | input | 1 | Load a new ring base pointer |
| base_blk | input | ADDR_W-4 | Ring base as a block index |
| doorbell | input | 1 | Producer has posted work |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_blk | output | ADDR_W-4 | Block index to read |
| mem_rd_data | input | 128 | Descriptor, valid the cycle after the request |
| out_valid | output | 1 | Output descriptor valid |
| out_ready | input | 1 | Downstream accepts |
| out_desc | output | 128 | Raw descriptor |
| out_type | output | 6 | Decoded type field |
| out_chain | output | 1 | Chain flag |
| out_ioc | output | 1 | Interrupt-on-completion flag |
| out_imm | output | 1 | Immediate-data flag |

## Verification
A wrong cycle state shows up within one fetch. The block either stalls on a descriptor it owns or outputs one it does not own, so `out_desc` bit 96 stops matching the expected value. A pointer error shows up as the wrong `mem_rd_blk` on the next read, or as the wrong payload emerging three cycles later. A mishandled link or toggle either leaks a type-6 descriptor onto the stream or stops consumption at the first descriptor past the link. A lost or spurious pending doorbell changes how many read requests follow a drained ring.

// File: rtl/ring_desc_pkg.sv
`timescale 1ns/1ps
package ring_desc_pkg;
  localparam int DESC_W    = 128;
  localparam int CTRL_LO   = 96;
  localparam int CYC_BIT   = CTRL_LO + 0;
  localparam int TGL_BIT   = CTRL_LO + 1;
  localparam int CHAIN_BIT = CTRL_LO + 4;
  localparam int IOC_BIT   = CTRL_LO + 5;
  localparam int IMM_BIT   = CTRL_LO + 6;
  localparam int TYPE_LO   = CTRL_LO + 10;
  localparam int TYPE_W    = 6;

  localparam logic [TYPE_W-1:0] KIND_LINK = 6'd6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } fetch_st_e;

  typedef struct packed {
    logic [DESC_W-1:0] raw;
    logic              owned_bit;
    logic [TYPE_W-1:0] kind;
    logic              is_link;
    logic              toggle;
    logic              chain;
    logic              ioc;
    logic              imm;
  } desc_fields_t;
endpackage

// File: rtl/ring_desc_decode.sv
`timescale 1ns/1ps
module ring_desc_decode
  import ring_desc_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output desc_fields_t      fld
);
  always_comb begin
    fld.raw       = desc;
    fld.owned_bit = desc[CYC_BIT];
    fld.kind      = desc[TYPE_LO +: TYPE_W];
    fld.is_link   = (desc[TYPE_LO +: TYPE_W] == KIND_LINK);
    fld.toggle    = desc[TGL_BIT];
    fld.chain     = desc[CHAIN_BIT];
    fld.ioc       = desc[IOC_BIT];
    fld.imm       = desc[IMM_BIT];
  end
endmodule

// File: rtl/ring_desc_ptr.sv
`timescale 1ns/1ps
module ring_desc_ptr #(
  parameter int ADDR_W = 16,
  localparam int BLK_W = ADDR_W - 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_load,
  input  logic [BLK_W-1:0] base_blk,
  input  logic             jump,
  input  logic [BLK_W-1:0] jump_blk,
  input  logic             flip,
  input  logic             step,
  output logic [BLK_W-1:0] blk,
  output logic             cyc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      blk <= '0;
      cyc <= 1'b1;
    end else if (base_load) begin
      blk <= base_blk;
      cyc <= 1'b1;
    end else if (jump) begin
      blk <= jump_blk;
      if (flip) cyc <= ~cyc;
    end else if (step) begin
      blk <= blk + BLK_W'(1);
    end
  end
endmodule

// File: rtl/ring_desc_out.sv
`timescale 1ns/1ps
module ring_desc_out
  import ring_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic              ready,
  input  logic [DESC_W-1:0] din,
  input  logic [TYPE_W-1:0] kind,
  input  logic              chain,
  input  logic              ioc,
  input  logic              imm,
  output logic              valid,
  output logic [DESC_W-1:0] dout,
  output logic [TYPE_W-1:0] otype,
  output logic              ochain,
  output logic              oioc,
  output logic              oimm
);
  always_ff @(posedge clk) begin
    if (rst || flush) valid <= 1'b0;
    else if (load) valid <= 1'b1;
    else if (valid && ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      otype  <= '0;
      ochain <= 1'b0;
      oioc   <= 1'b0;
      oimm   <= 1'b0;
    end else if (load) begin
      dout   <= din;
      otype  <= kind;
      ochain <= chain;
      oioc   <= ioc;
      oimm   <= imm;
    end
  end
endmodule

// File: rtl/ring_desc_consumer.sv
`timescale 1ns/1ps
module ring_desc_consumer
  import ring_desc_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int BLK_W = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_load,
  input  logic [BLK_W-1:0]  base_blk,
  input  logic              doorbell,
  output logic              mem_rd_en,
  output logic [BLK_W-1:0]  mem_rd_blk,
  input  logic [DESC_W-1:0] mem_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DESC_W-1:0] out_desc,
  output logic [TYPE_W-1:0] out_type,
  output logic              out_chain,
  output logic              out_ioc,
  output logic              out_imm
);
  fetch_st_e    st_q, st_d;
  desc_fields_t fld;
  logic         pend_q;
  logic         cyc_state;
  logic [BLK_W-1:0] deq_blk;
  logic         do_jump, do_step, do_load, mismatch;

  ring_desc_decode u_dec (
    .desc (mem_rd_data),
    .fld  (fld)
  );

  ring_desc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .base_load (base_load),
    .base_blk  (base_blk),
    .jump      (do_jump),
    .jump_blk  (fld.raw[ADDR_W-1:4]),
    .flip      (fld.toggle),
    .step      (do_step),
    .blk       (deq_blk),
    .cyc       (cyc_state)
  );

  ring_desc_out u_out (
    .clk    (clk),
    .rst    (rst),
    .flush  (base_load),
    .load   (do_load),
    .ready  (out_ready),
    .din    (fld.raw),
    .kind   (fld.kind),
    .chain  (fld.chain),
    .ioc    (fld.ioc),
    .imm    (fld.imm),
    .valid  (out_valid),
    .dout   (out_desc),
    .otype  (out_type),
    .ochain (out_chain),
    .oioc   (out_ioc),
    .oimm   (out_imm)
  );

  assign mismatch = (fld.owned_bit != cyc_state);

  always_comb begin
    st_d    = st_q;
    do_jump = 1'b0;
    do_step = 1'b0;
    do_load = 1'b0;
    unique case (st_q)
      ST_IDLE: if (doorbell) st_d = ST_READ;
      ST_READ: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mismatch) begin
          st_d = (pend_q || doorbell) ? ST_READ : ST_IDLE;
        end else if (fld.is_link) begin
          do_jump = 1'b1;
          st_d    = ST_READ;
        end else begin
          do_load = 1'b1;
          st_d    = ST_HOLD;
        end
      end
      ST_HOLD: if (out_ready) begin
        do_step = 1'b1;
        st_d    = ST_READ;
      end
      default: st_d = ST_IDLE;
    endcase
    if (base_load) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (rst || base_load)                     pend_q <= 1'b0;
    else if (st_q == ST_WAIT && mismatch)     pend_q <= 1'b0;
    else if (doorbell && st_q != ST_IDLE)     pend_q <= 1'b1;
  end

  assign mem_rd_en  = (st_q == ST_READ);
  assign mem_rd_blk = deq_blk;
endmodule

// File: rtl/ring_desc_consumer_chk.sv
`timescale 1ns/1ps
module ring_desc_consumer_chk (
  input logic         clk,
  input logic         rst,
  input logic         base_load,
  input logic         mem_rd_en,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_desc,
  input logic [5:0]   out_type,
  input logic         cyc_state
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !mem_rd_en));

  // R3
  owned_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_desc[96] == cyc_state));

  // R6
  no_link_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_type != 6'd6));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !base_load) |=> (out_valid && $stable(out_desc)));

  // R10
  base_abort_chk: assert property (@(posedge clk) disable iff (rst)
    base_load |=> (!out_valid && !mem_rd_en));

  // R11
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind ring_desc_consumer ring_desc_consumer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .base_load (base_load),
  .mem_rd_en (mem_rd_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_desc  (out_desc),
  .out_type  (out_type),
  .cyc_state (cyc_state)
);

// File: tb/ring_desc_consumer_tb.sv
`timescale 1ns/1ps
module ring_desc_consumer_tb;
  localparam int ADDR_W = 16;
  localparam int BLK_W  = ADDR_W - 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_load = 1'b0;
  logic [BLK_W-1:0] base_blk = '0;
  logic doorbell = 1'b0;
  logic mem_rd_en;
  logic [BLK_W-1:0] mem_rd_blk;
  logic [127:0] mem_rd_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [127:0] out_desc;
  logic [5:0] out_type;
  logic out_chain, out_ioc, out_imm;

  logic [127:0] mem [0:255];
  int checks = 0;
  int failures = 0;
  int reads = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ring_desc_consumer #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .base_load(base_load), .base_blk(base_blk),
    .doorbell(doorbell), .mem_rd_en(mem_rd_en), .mem_rd_blk(mem_rd_blk),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_desc(out_desc), .out_type(out_type), .out_chain(out_chain),
    .out_ioc(out_ioc), .out_imm(out_imm)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_blk[7:0]];
      reads <= reads + 1;
    end
  end

  function automatic logic [127:0] mk(input logic [5:0] t, input logic c,
                                      input logic [2:0] fl, input logic [31:0] w0);
    logic [31:0] ctrl;
    ctrl = (32'(t) << 10) | (32'(fl) << 4) | 32'(c);
    return {ctrl, 32'h0, 32'h0, w0};
  endfunction

  function automatic logic [127:0] mklink(input logic [63:0] p, input logic c,
                                          input logic tgl);
    logic [31:0] ctrl;
    ctrl = (32'd6 << 10) | (32'(tgl) << 1) | 32'(c);
    return {ctrl, 32'h0, p[63:32], p[31:0]};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ring_bell();
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
  endtask

  task automatic load_base(input logic [BLK_W-1:0] b);
    @(negedge clk) begin base_blk = b; base_load = 1'b1; end
    @(negedge clk) base_load = 1'b0;
  endtask

  // waits for out_valid, checks contents, then accepts it
  task automatic take(input string req, input logic [127:0] exp);
    int n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    chk({req, " valid"}, 128'(out_valid), 128'(1));
    chk({req, " desc"}, out_desc, exp);
    chk({req, " type"}, 128'(out_type), 128'(exp[111:106]));
    chk({req, " flags"}, 128'({out_imm, out_ioc, out_chain}), 128'(exp[102:100]));
    out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
  endtask

  task automatic expect_quiet(input string req, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(req, 128'(seen), 128'(0));
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", 128'(out_valid), 0);
    chk("R1 rd_en in reset", 128'(mem_rd_en), 0);
    @(negedge clk) rst = 1'b0;
    chk("R1 valid after reset", 128'(out_valid), 0);
  endtask

  task automatic t_basic();
    mem[16] = mk(6'd1, 1'b1, 3'b001, 32'hA001);
    mem[17] = mk(6'd2, 1'b1, 3'b110, 32'hA002);
    mem[18] = mk(6'd3, 1'b1, 3'b010, 32'hA003);
    mem[19] = mk(6'd8, 1'b0, 3'b000, 32'hA004);
    load_base(12'd16);
    ring_bell();
    chk("R11 latency edge1", 128'(out_valid), 0);
    @(negedge clk) chk("R11 latency edge2", 128'(out_valid), 0);
    @(negedge clk) chk("R11 latency edge3", 128'(out_valid), 1);
    chk("R2 first block from base", out_desc, mem[16]);
    // stall with ready low
    repeat (4) @(negedge clk);
    chk("R8 held while not ready", out_desc, mem[16]);
    take("R3 R4 normal", mem[16]);
    take("R4 setup ioc imm", mem[17]);
    take("R8 advance data", mem[18]);
    expect_quiet("R5 not-owned gives no output", 12);
    chk("R5 idle no reads", 128'(mem_rd_en), 0);
    mem[19] = mk(6'd8, 1'b1, 3'b000, 32'hA004);
    ring_bell();
    take("R5 same block reread after doorbell", mem[19]);
  endtask

  task automatic t_link();
    mem[64]  = mk(6'd1, 1'b1, 3'b000, 32'hB001);
    mem[65]  = mklink(64'hDEAD_0000_00AB_0808, 1'b1, 1'b1);
    mem[128] = mk(6'd5, 1'b0, 3'b001, 32'hB002);
    mem[129] = mklink(64'h0000_0000_0000_0400, 1'b0, 1'b0);
    mem[130] = mk(6'd1, 1'b0, 3'b000, 32'hBBAD);
    load_base(12'd64);
    ring_bell();
    take("R6 before link", mem[64]);
    take("R6 R7 after toggling link", mem[128]);
    chk("R7 cycle bit of output", 128'(out_desc[96]), 0);
    // second link (no toggle) back to 64 whose cycle bit is 1 -> stop
    expect_quiet("R7 no-toggle link keeps state", 15);
    chk("R6 link ended at block 64", 128'(mem_rd_blk), 128'(64));
    mem[64] = mk(6'd7, 1'b0, 3'b000, 32'hB003);
    ring_bell();
    take("R7 cycle state still 0", mem[64]);
  endtask

  task automatic t_pending();
    int r0;
    mem[0] = mk(6'd1, 1'b1, 3'b000, 32'hC001);
    mem[1] = mk(6'd1, 1'b0, 3'b000, 32'hC002);
    mem[2] = mk(6'd1, 1'b0, 3'b000, 32'hC003);
    load_base(12'd0);
    ring_bell();
    while (!out_valid) @(negedge clk);
    r0 = reads;
    take("R9 control first", mem[0]);
    repeat (10) @(negedge clk);
    chk("R9 single read without pending", 128'(reads - r0), 1);
    mem[1] = mk(6'd1, 1'b1, 3'b000, 32'hC002);
    ring_bell();
    while (!out_valid) @(negedge clk);
    ring_bell();
    r0 = reads;
    take("R9 pending first", mem[1]);
    repeat (10) @(negedge clk);
    chk("R9 reread with pending doorbell", 128'(reads - r0), 2);
  endtask

  task automatic t_abort();
    mem[32] = mk(6'd4, 1'b1, 3'b000, 32'hD001);
    mem[48] = mk(6'd2, 1'b1, 3'b000, 32'hD002);
    load_base(12'd32);
    ring_bell();
    while (!out_valid) @(negedge clk);
    @(negedge clk) begin base_blk = 12'd48; base_load = 1'b1; end
    @(negedge clk) base_load = 1'b0;
    chk("R10 valid dropped", 128'(out_valid), 0);
    chk("R10 no read", 128'(mem_rd_en), 0);
    expect_quiet("R10 idle after abort", 5);
    ring_bell();
    take("R10 R2 fetch from new base", mem[48]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_link();
    t_pending();
    t_abort();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule